// File: doc/BRIEF.md
# Mailbox Interrupt Controller

This block sits beside a two-port shared memory and turns accesses to two reserved words into interrupts between the ports. The word at the all-ones address belongs to the right port, and the word one below it belongs to the left port. A port posts a message by writing into the other port's word. That write raises the owner's interrupt. The owner reads its own word, and that read drops the interrupt. The block never stores the message. It only watches the enables, the direction strobe, the output enable, the address and the arbitration busy flag of each port.

Each port's access is sampled on the rising clock edge. The two interrupt lines are registered and active-low. A busy flag that is active toward a port suppresses both things that port can cause: raising the other side's interrupt, and clearing its own.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: After reset both interrupt outputs are high (inactive), and they stay high until a qualifying write occurs.
- R2: A left-port write (l_en_n=0, l_rd=0) to the all-ones address, with l_busy_n=1, drives r_irq_n low on the next rising edge.
- R3: A right-port write (r_en_n=0, r_rd=0) to address all-ones minus one, with r_busy_n=1, drives l_irq_n low on the next rising edge.
- R4: An owner read of its own mailbox drives that port's interrupt output high on the next rising edge. An owner read needs en_n=0, rd=1, oe_n=0 and busy_n=1. The left mailbox is all-ones minus one and the right mailbox is all-ones.
- R5: A port that reads the other port's mailbox leaves both interrupt outputs unchanged.
- R6: While busy_n=0 on a port, that port's write to the other port's mailbox does not assert the other port's interrupt.
- R7: While busy_n=0 on a port, that port's read of its own mailbox does not clear its interrupt.
- R8: Neither of the following changes an interrupt: a read with oe_n=1 or en_n=1, or a write to any address other than the other port's mailbox, including a write to the port's own mailbox.
- R9: When one interrupt is set and cleared in the same cycle, the set wins and the output stays low.
- R10: An interrupt output keeps its value in every cycle that has neither a set nor a clear for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_en_n | input | 1 | Left access enable, active low |
| l_rd | input | 1 | Left direction: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | AW | Left word address |
| l_busy_n | input | 1 | Busy toward left port, active low |
| r_en_n | input | 1 | Right access enable, active low |
| r_rd | input | 1 | Right direction: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | AW | Right word address |
| r_busy_n | input | 1 | Busy toward right port, active low |
| l_irq_n | output | 1 | Interrupt to the left port, active low |
| r_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
A set or a clear takes effect at the first rising edge that samples the access, so each interrupt output is due one edge after the stimulus. The bench applies inputs on the falling edge. A behavioural model updates on the rising edge. Both outputs are compared with the model at the next falling edge, so every comparison falls half a period after the edge that is due to change the output. Directed steps also check literal expected levels at that same point, before the next stimulus is applied.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

  // Mailbox word owned by a side: all-ones for right, all-ones minus one for left.
  function automatic logic [31:0] mbox_word(input int aw, input side_e s);
    logic [31:0] top;
    top = (32'd1 << aw) - 32'd1;
    return (s == SIDE_R) ? top : top - 32'd1;
  endfunction

  function automatic side_e peer_of(input side_e s);
    return (s == SIDE_L) ? SIDE_R : SIDE_L;
  endfunction
endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
  import mbox_irq_pkg::*;
#(
  parameter int    AW   = 14,
  parameter side_e SIDE = SIDE_L
) (
  input  logic          en_n,
  input  logic          rd,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic          busy_n,
  output logic          set_peer,
  output logic          clr_own
);
  localparam logic [31:0]   OWN_W  = mbox_word(AW, SIDE);
  localparam logic [31:0]   PEER_W = mbox_word(AW, peer_of(SIDE));
  localparam logic [AW-1:0] OWN_A  = OWN_W[AW-1:0];
  localparam logic [AW-1:0] PEER_A = PEER_W[AW-1:0];

  logic wr_cyc, rd_cyc;
  assign wr_cyc = !en_n && !rd;
  assign rd_cyc = !en_n && rd && !oe_n;

  assign set_peer = wr_cyc && (addr == PEER_A) && busy_n;
  assign clr_own  = rd_cyc && (addr == OWN_A)  && busy_n;
endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= 1'b0;
    else if (set) pend <= 1'b1;
    else if (clr) pend <= 1'b0;
  end

  assign irq_n = !pend;

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> !irq_n);
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> irq_n);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(irq_n));
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_irq_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_en_n,
  input  logic          l_rd,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic          l_busy_n,
  input  logic          r_en_n,
  input  logic          r_rd,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic          r_busy_n,
  output logic          l_irq_n,
  output logic          r_irq_n
);
  localparam int NP = 2;

  logic [NP-1:0]         p_en_n, p_rd, p_oe_n, p_busy_n;
  logic [NP-1:0][AW-1:0] p_addr;
  logic [NP-1:0]         set_peer, clr_own, irq_n;

  assign p_en_n   = {r_en_n, l_en_n};
  assign p_rd     = {r_rd, l_rd};
  assign p_oe_n   = {r_oe_n, l_oe_n};
  assign p_busy_n = {r_busy_n, l_busy_n};
  assign p_addr   = {r_addr, l_addr};

  // Named events for the checks below.
  logic left_raises_right, right_raises_left, left_clears_own, right_clears_own;
  assign left_raises_right = set_peer[0];
  assign right_raises_left = set_peer[1];
  assign left_clears_own   = clr_own[0];
  assign right_clears_own  = clr_own[1];

  for (genvar g = 0; g < NP; g++) begin : g_side
    mbox_port_decode #(.AW(AW), .SIDE(side_e'(g))) u_dec (
      .en_n(p_en_n[g]), .rd(p_rd[g]), .oe_n(p_oe_n[g]),
      .addr(p_addr[g]), .busy_n(p_busy_n[g]),
      .set_peer(set_peer[g]), .clr_own(clr_own[g])
    );
    mbox_irq_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set(set_peer[NP-1-g]), .clr(clr_own[g]),
      .irq_n(irq_n[g])
    );
  end

  assign l_irq_n = irq_n[0];
  assign r_irq_n = irq_n[1];

  localparam logic [AW-1:0] TOP_A = {AW{1'b1}};
  localparam logic [AW-1:0] LMB_A = TOP_A - 1'b1;

  a_r2_left_post: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_en_n && !l_rd && l_addr == TOP_A && l_busy_n) |=> !r_irq_n);
  a_r3_right_post: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_en_n && !r_rd && r_addr == LMB_A && r_busy_n) |=> !l_irq_n);
  a_r6_busy_blocks_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n && r_irq_n) |=> r_irq_n);
  a_r7_busy_blocks_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n && !l_irq_n) |=> !l_irq_n);
  a_r5_only_owner_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_irq_n && !right_clears_own) |=> !r_irq_n);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (l_irq_n && !right_raises_left) |=> l_irq_n);
  a_r9_events_exclusive_left: assert property (@(posedge clk) disable iff (!rst_n)
    (left_raises_right && right_clears_own) |=> !r_irq_n);
  a_r4_left_clear_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (left_clears_own && !right_raises_left) |=> l_irq_n);
endmodule

// File: tb/mbox_irq_ctrl_tb_top.sv
module mbox_irq_ctrl_tb_top;
  localparam int AW = 14;
  localparam logic [AW-1:0] RMB = {AW{1'b1}};
  localparam logic [AW-1:0] LMB = RMB - 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_en_n = 1, l_rd = 1, l_oe_n = 1, l_busy_n = 1;
  logic r_en_n = 1, r_rd = 1, r_oe_n = 1, r_busy_n = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string tag = "R1";
  bit model_l = 0, model_r = 0;  // pending, active-high

  always #5 clk = ~clk;

  mbox_irq_ctrl #(.AW(AW)) dut_i (
    .clk, .rst_n, .l_en_n, .l_rd, .l_oe_n, .l_addr, .l_busy_n,
    .r_en_n, .r_rd, .r_oe_n, .r_addr, .r_busy_n, .l_irq_n, .r_irq_n
  );

  // Behavioural reference: which events happen this edge, then update.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_l = 0; model_r = 0;
    end else begin
      bit up_r, dn_r, up_l, dn_l;
      up_r = (l_en_n == 0) && (l_rd == 0) && (l_addr == RMB) && l_busy_n;
      up_l = (r_en_n == 0) && (r_rd == 0) && (r_addr == LMB) && r_busy_n;
      dn_l = (l_en_n == 0) && l_rd && (l_oe_n == 0) && (l_addr == LMB) && l_busy_n;
      dn_r = (r_en_n == 0) && r_rd && (r_oe_n == 0) && (r_addr == RMB) && r_busy_n;
      if (up_l) model_l = 1; else if (dn_l) model_l = 0;
      if (up_r) model_r = 1; else if (dn_r) model_r = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      compared++;
      if (l_irq_n !== !model_l || r_irq_n !== !model_r) begin
        mismatched++;
        $display("FAIL %s model: l_irq_n=%b r_irq_n=%b expected %b %b",
                 tag, l_irq_n, r_irq_n, !model_l, !model_r);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic idle();
    l_en_n = 1; l_rd = 1; l_oe_n = 1; l_busy_n = 1; l_addr = '0;
    r_en_n = 1; r_rd = 1; r_oe_n = 1; r_busy_n = 1; r_addr = '0;
  endtask

  task automatic lacc(input bit en_n, rd, oe_n, busy_n, input logic [AW-1:0] a);
    l_en_n = en_n; l_rd = rd; l_oe_n = oe_n; l_busy_n = busy_n; l_addr = a;
  endtask

  task automatic racc(input bit en_n, rd, oe_n, busy_n, input logic [AW-1:0] a);
    r_en_n = en_n; r_rd = rd; r_oe_n = oe_n; r_busy_n = busy_n; r_addr = a;
  endtask

  // Inputs already set; let one edge pass, then check literal levels.
  task automatic expect_after(input bit el, er, input string t);
    tag = t;
    @(posedge clk); @(negedge clk);
    compared++;
    if (l_irq_n !== el || r_irq_n !== er) begin
      mismatched++;
      $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected %b %b", t, l_irq_n, r_irq_n, el, er);
    end
    idle();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    compared++;
    if (l_irq_n !== 1'b1 || r_irq_n !== 1'b1) begin
      mismatched++;
      $display("FAIL R1 reset: %b %b expected 1 1", l_irq_n, r_irq_n);
    end
    rst_n = 1;
    idle();                       expect_after(1, 1, "R1");
    lacc(0, 0, 1, 1, LMB);        expect_after(1, 1, "R8 own-mailbox write");
    lacc(0, 0, 1, 1, RMB - 2);    expect_after(1, 1, "R8 other address");
    lacc(0, 0, 1, 0, RMB);        expect_after(1, 1, "R6 busy left");
    lacc(0, 0, 1, 1, RMB);        expect_after(1, 0, "R2");
    idle();                       expect_after(1, 0, "R10");
    lacc(0, 1, 0, 1, RMB);        expect_after(1, 0, "R5 left reads right box");
    racc(0, 1, 1, 1, RMB);        expect_after(1, 0, "R8 oe off");
    racc(1, 1, 0, 1, RMB);        expect_after(1, 0, "R8 en off");
    racc(0, 1, 0, 0, RMB);        expect_after(1, 0, "R7 busy right");
    racc(0, 1, 0, 1, RMB);        expect_after(1, 1, "R4 right clear");
    racc(0, 0, 1, 0, LMB);        expect_after(1, 1, "R6 busy right");
    racc(0, 0, 1, 1, LMB);        expect_after(0, 1, "R3");
    racc(0, 1, 0, 1, LMB);        expect_after(0, 1, "R5 right reads left box");
    lacc(0, 1, 0, 0, LMB);        expect_after(0, 1, "R7 busy left");
    lacc(0, 1, 0, 1, LMB); racc(0, 0, 1, 1, LMB);
                                  expect_after(0, 1, "R9 left set+clear");
    lacc(0, 1, 0, 1, LMB);        expect_after(1, 1, "R4 left clear");
    lacc(0, 0, 1, 1, RMB);        expect_after(1, 0, "R2 again");
    lacc(0, 0, 1, 1, RMB); racc(0, 1, 0, 1, RMB);
                                  expect_after(1, 0, "R9 right set+clear");
    tag = "R10 random";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      lacc($urandom_range(3) == 0, $urandom_range(1), $urandom_range(1),
           $urandom_range(4) != 0, ($urandom_range(2) == 0) ? AW'($urandom) : RMB - AW'($urandom_range(1)));
      racc($urandom_range(3) == 0, $urandom_range(1), $urandom_range(1),
           $urandom_range(4) != 0, ($urandom_range(2) == 0) ? AW'($urandom) : RMB - AW'($urandom_range(1)));
    end
    @(negedge clk); idle();
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule